// File: doc/BRIEF.md
# Dual-Mode Pixel Counter Pair

This block is the digital counting element of one detector pixel. A discriminator output (the hit) passes through a synchroniser and drives a 13-bit counter store. The acquisition window is set by a shutter input. In the two split modes, the store is two fields. The upper 5 bits measure time-over-threshold. The lower 8 bits hold either time-of-arrival or an event count. In the two long modes, the whole 13-bit store acts as one time-of-arrival or event counter, and no time-over-threshold is kept. Every counter stops at all-ones instead of wrapping.

A new acquisition starts when the shutter opens, and the store clears at that point. The mode word is taken only while the shutter is closed. After the shutter closes, a load pulse copies the store into a 13-bit shift register. Each shift pulse then presents the next bit on a single serial output, most significant bit first.

Top module: `pixel_cnt_pair`

## Requirements
- R1: The hit passes through two synchroniser flops before use. A hit that is high for N whole clock cycles adds exactly N to the time-over-threshold field when the window is long enough.
- R2: In mode 2'b00 and mode 2'b01, bits [12:8] of the store count the clock cycles during which the synchronised hit is high while the shutter is open.
- R3: In mode 2'b00, bits [7:0] start counting on the first synchronised hit rising edge. They then add one every open-shutter cycle until the shutter closes. Later rising edges neither restart nor speed up this count.
- R4: In mode 2'b01, bits [7:0] add one for each synchronised hit rising edge while the shutter is open.
- R5: In mode 2'b10, all 13 bits form a single time-of-arrival counter with the same start rule as R3. No time-over-threshold value is stored.
- R6: In mode 2'b11, all 13 bits form a single counter of synchronised hit rising edges.
- R7: Every counter in every mode stops at its all-ones value: 31 for the 5-bit field, 255 for the 8-bit field and 8191 for the 13-bit store.
- R8: The first clock edge with the shutter high after it was low clears the whole store and the time-of-arrival start flag.
- R9: The mode word is registered only on edges where the shutter is low. A change while the shutter is open has no effect on the running acquisition.
- R10: While the shutter is low, hits leave the store unchanged.
- R11: A load pulse copies the store into the shift register, and the output shows bit 12 on the next cycle. Each shift pulse moves the register one place toward the MSB and fills zeros at bit 0. Load wins over shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Asynchronous discriminator output |
| shutter_i | input | 1 | Acquisition window, high = open |
| mode_i | input | 2 | 00 split ToT/ToA, 01 split ToT/events, 10 long ToA, 11 long events |
| ro_load_i | input | 1 | Copy the store into the shift register |
| ro_shift_i | input | 1 | Advance the shift register one bit |
| ro_data_o | output | 1 | Serial readout, MSB first |

## Verification
A hit driven on a falling edge reaches the counting logic two edges later. Its first increment therefore lands on the third rising edge after it is applied. The bench derives every expected value from that three-edge delay: time-over-threshold equals the hit length, and time-of-arrival equals the edges from hit to shutter drop minus two. All stimulus changes on falling edges. The bench waits at least two cycles after closing the shutter before it reads back. A load shows bit 12 one edge later, and each shift shows the next bit one edge after it. The bench samples the output on the falling edge that follows each of those edges.

// File: rtl/pixel_cnt_pkg.sv
package pixel_cnt_pkg;

    typedef enum logic [1:0] {
        MODE_TOT_TOA  = 2'b00,
        MODE_TOT_EVT  = 2'b01,
        MODE_LONG_TOA = 2'b10,
        MODE_LONG_EVT = 2'b11
    } cnt_mode_e;

    function automatic logic is_long(input cnt_mode_e m);
        return (m == MODE_LONG_TOA) || (m == MODE_LONG_EVT);
    endfunction

endpackage

// File: rtl/pixel_hit_sync.sv
module pixel_hit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic level_o,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                s_d       = s_q;
                s_d.chain = {s_q.chain[STAGES-2:0], hit_i};
                s_d.last  = s_q.chain[STAGES-1];
            end
        end else begin : g_single
            always_comb begin
                s_d       = s_q;
                s_d.chain = hit_i;
                s_d.last  = s_q.chain[0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.chain[STAGES-1];
    assign rise_o  = s_q.chain[STAGES-1] & ~s_q.last;

endmodule

// File: rtl/pixel_cnt_core.sv
module pixel_cnt_core
    import pixel_cnt_pkg::*;
#(
    parameter int TOT_W = 5,
    parameter int TOA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   level_i,
    input  logic                   rise_i,
    input  logic                   shutter_i,
    input  logic [1:0]             mode_i,
    output logic [TOT_W+TOA_W-1:0] cnt_o,
    output cnt_mode_e              mode_o,
    output logic                   run_o,
    output logic                   start_o
);

    localparam int CNT_W = TOT_W + TOA_W;
    localparam logic [TOT_W-1:0] TOT_MAX = '1;
    localparam logic [TOA_W-1:0] TOA_MAX = '1;
    localparam logic [CNT_W-1:0] ALL_MAX = '1;

    typedef struct packed {
        logic [TOT_W-1:0] tot;
        logic [TOA_W-1:0] low;
        logic             armed;
        logic             shut;
        cnt_mode_e        mode;
    } core_t;

    core_t c_d, c_q;
    logic  run, start;
    logic [CNT_W-1:0] full_q;

    assign run    = shutter_i & c_q.shut;
    assign start  = shutter_i & ~c_q.shut;
    assign full_q = {c_q.tot, c_q.low};

    always_comb begin
        c_d      = c_q;
        c_d.shut = shutter_i;
        if (!shutter_i) c_d.mode = cnt_mode_e'(mode_i);
        if (start) begin
            c_d.tot   = '0;
            c_d.low   = '0;
            c_d.armed = 1'b0;
        end else if (run) begin
            if (rise_i) c_d.armed = 1'b1;
            unique case (c_q.mode)
                MODE_TOT_TOA: begin
                    if (level_i && c_q.tot != TOT_MAX) c_d.tot = c_q.tot + 1'b1;
                    if ((c_q.armed || rise_i) && c_q.low != TOA_MAX)
                        c_d.low = c_q.low + 1'b1;
                end
                MODE_TOT_EVT: begin
                    if (level_i && c_q.tot != TOT_MAX) c_d.tot = c_q.tot + 1'b1;
                    if (rise_i && c_q.low != TOA_MAX) c_d.low = c_q.low + 1'b1;
                end
                MODE_LONG_TOA: begin
                    if ((c_q.armed || rise_i) && full_q != ALL_MAX)
                        {c_d.tot, c_d.low} = full_q + 1'b1;
                end
                MODE_LONG_EVT: begin
                    if (rise_i && full_q != ALL_MAX)
                        {c_d.tot, c_d.low} = full_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{tot: '0, low: '0, armed: 1'b0, shut: 1'b0, mode: MODE_TOT_TOA};
        else        c_q <= c_d;
    end

    assign cnt_o   = full_q;
    assign mode_o  = c_q.mode;
    assign run_o   = run;
    assign start_o = start;

endmodule

// File: rtl/pixel_ro_shift.sv
module pixel_ro_shift #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] par_i,
    input  logic         load_i,
    input  logic         shift_i,
    output logic         ser_o
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i)       sr_d = par_i;
        else if (shift_i) sr_d = {sr_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign ser_o = sr_q[W-1];

endmodule

// File: rtl/pixel_cnt_pair.sv
module pixel_cnt_pair
    import pixel_cnt_pkg::*;
#(
    parameter int TOT_W       = 5,
    parameter int TOA_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic       shutter_i,
    input  logic [1:0] mode_i,
    input  logic       ro_load_i,
    input  logic       ro_shift_i,
    output logic       ro_data_o
);

    localparam int CNT_W = TOT_W + TOA_W;

    logic             hit_lvl, hit_rise;
    logic [CNT_W-1:0] cnt_w;
    cnt_mode_e        mode_w;
    logic             run_w, start_w;

    pixel_hit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit_i),
        .level_o (hit_lvl),
        .rise_o  (hit_rise)
    );

    pixel_cnt_core #(.TOT_W(TOT_W), .TOA_W(TOA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (hit_lvl),
        .rise_i    (hit_rise),
        .shutter_i (shutter_i),
        .mode_i    (mode_i),
        .cnt_o     (cnt_w),
        .mode_o    (mode_w),
        .run_o     (run_w),
        .start_o   (start_w)
    );

    pixel_ro_shift #(.W(CNT_W)) u_ro (
        .clk     (clk),
        .rst_n   (rst_n),
        .par_i   (cnt_w),
        .load_i  (ro_load_i),
        .shift_i (ro_shift_i),
        .ser_o   (ro_data_o)
    );

endmodule

// File: rtl/pixel_cnt_pair_chk.sv
module pixel_cnt_pair_chk
    import pixel_cnt_pkg::*;
#(
    parameter int TOT_W = 5,
    parameter int TOA_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   shutter_i,
    input logic                   ro_load_i,
    input logic                   ro_data_o,
    input logic [TOT_W+TOA_W-1:0] cnt_w,
    input cnt_mode_e              mode_w,
    input logic                   run_w,
    input logic                   start_w
);
    localparam int CNT_W = TOT_W + TOA_W;

    logic split;
    assign split = !is_long(mode_w);

    // R7: split-mode ToT field never wraps
    assert_tot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && split && cnt_w[CNT_W-1:TOA_W] == '1) |=> (cnt_w[CNT_W-1:TOA_W] == '1));

    // R7: split-mode low field never wraps
    assert_low_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && split && cnt_w[TOA_W-1:0] == '1) |=> (cnt_w[TOA_W-1:0] == '1));

    // R7: long store never wraps
    assert_long_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && !split && cnt_w == '1) |=> (cnt_w == '1));

    // R8: window start clears the store
    assert_start_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (cnt_w == '0));

    // R9: mode held while shutter open
    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutter_i |=> $stable(mode_w));

    // R10: store frozen while shutter closed
    assert_closed_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !shutter_i |=> $stable(cnt_w));

    // R11: load shows store MSB next cycle
    assert_load_msb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ro_load_i |=> (ro_data_o == $past(cnt_w[CNT_W-1])));

endmodule

bind pixel_cnt_pair pixel_cnt_pair_chk #(.TOT_W(TOT_W), .TOA_W(TOA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shutter_i (shutter_i),
    .ro_load_i (ro_load_i),
    .ro_data_o (ro_data_o),
    .cnt_w     (cnt_w),
    .mode_w    (mode_w),
    .run_w     (run_w),
    .start_w   (start_w)
);

// File: tb/pixel_cnt_pair_test.sv
module pixel_cnt_pair_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_i = 1'b0;
    logic       shutter_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       ro_load_i = 1'b0;
    logic       ro_shift_i = 1'b0;
    logic       ro_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pixel_cnt_pair uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit_i),
        .shutter_i  (shutter_i),
        .mode_i     (mode_i),
        .ro_load_i  (ro_load_i),
        .ro_shift_i (ro_shift_i),
        .ro_data_o  (ro_data_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic open_win(input logic [1:0] m);
        mode_i = m;
        @(negedge clk);
        shutter_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic close_win();
        shutter_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int gap);
        hit_i = 1'b1;
        repeat (hi) @(negedge clk);
        hit_i = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic read_out(output logic [12:0] v, input bit with_shift);
        ro_load_i  = 1'b1;
        ro_shift_i = with_shift;
        @(negedge clk);
        ro_load_i  = 1'b0;
        ro_shift_i = 1'b0;
        for (int i = 12; i >= 0; i--) begin
            v[i] = ro_data_o;
            ro_shift_i = 1'b1;
            @(negedge clk);
            ro_shift_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [12:0] v;
        chk("R11 reset output", ro_data_o, 0);
        read_out(v, 1'b0);
        chk("R8 reset store", v, 0);
    endtask

    task automatic t_split_toa();
        logic [12:0] v;
        open_win(2'b00);
        pulse(7, 20);
        close_win();
        read_out(v, 1'b0);
        chk("R2 ToT field", v[12:8], 7);
        chk("R3 ToA field", v[7:0], 25);
        pulse(5, 5);
        read_out(v, 1'b0);
        chk("R10 closed ToT unchanged", v[12:8], 7);
        chk("R10 closed ToA unchanged", v[7:0], 25);
        open_win(2'b00);
        pulse(7, 20);
        pulse(4, 10);
        close_win();
        read_out(v, 1'b0);
        chk("R1 ToT sums hit lengths", v[12:8], 11);
        chk("R3 ToA no restart", v[7:0], 39);
    endtask

    task automatic t_split_evt();
        logic [12:0] v;
        open_win(2'b01);
        for (int i = 0; i < 5; i++) pulse(2, 3);
        close_win();
        read_out(v, 1'b0);
        chk("R4 event field", v[7:0], 5);
        chk("R2 ToT in event mode", v[12:8], 10);
    endtask

    task automatic t_clear();
        logic [12:0] v;
        open_win(2'b01);
        repeat (6) @(negedge clk);
        close_win();
        read_out(v, 1'b0);
        chk("R8 cleared at window start", v, 0);
    endtask

    task automatic t_long();
        logic [12:0] v;
        open_win(2'b10);
        pulse(3, 50);
        close_win();
        read_out(v, 1'b0);
        chk("R5 long ToA value", v, 51);
        open_win(2'b11);
        for (int i = 0; i < 300; i++) pulse(1, 2);
        close_win();
        read_out(v, 1'b0);
        chk("R6 long event beyond 8 bits", v, 300);
    endtask

    task automatic t_mode_change();
        logic [12:0] v;
        open_win(2'b00);
        mode_i = 2'b10;
        pulse(7, 20);
        close_win();
        read_out(v, 1'b0);
        chk("R9 split ToT kept", v[12:8], 7);
        chk("R9 split ToA kept", v[7:0], 25);
        shutter_i = 1'b1;
        @(negedge clk);
        pulse(7, 20);
        close_win();
        read_out(v, 1'b0);
        chk("R9 new mode at next window", v, 25);
    endtask

    task automatic t_saturate();
        logic [12:0] v;
        open_win(2'b00);
        pulse(40, 300);
        close_win();
        read_out(v, 1'b0);
        chk("R7 ToT saturates", v[12:8], 31);
        chk("R7 ToA saturates", v[7:0], 255);
        open_win(2'b01);
        for (int i = 0; i < 300; i++) pulse(1, 2);
        close_win();
        read_out(v, 1'b0);
        chk("R7 event field saturates", v[7:0], 255);
        chk("R7 ToT saturates event mode", v[12:8], 31);
        open_win(2'b10);
        pulse(1, 8300);
        close_win();
        read_out(v, 1'b0);
        chk("R7 long ToA saturates", v, 8191);
        open_win(2'b11);
        for (int i = 0; i < 8200; i++) pulse(1, 2);
        close_win();
        read_out(v, 1'b0);
        chk("R7 long event saturates", v, 8191);
    endtask

    task automatic t_readout();
        logic [12:0] v;
        open_win(2'b00);
        pulse(5, 12);
        close_win();
        read_out(v, 1'b1);
        chk("R11 load beats shift ToT", v[12:8], 5);
        chk("R11 load beats shift ToA", v[7:0], 15);
        chk("R11 zero fill after 13 shifts", ro_data_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split_toa();
        t_split_evt();
        t_clear();
        t_long();
        t_mode_change();
        t_readout();
        t_saturate();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all R) actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule